// File: doc/BRIEF.md
# Microprogram Sequencer with Bit-Forcing Branches

This block steps a horizontally microcoded controller through its microroutines. Each machine cycle has a fixed length of four clocks. A two-bit phase counter splits it into an idle slot and three strobes, called T2, T3 and T4. The sequencer keeps the current micro-address and the current microword. It reads the next microword from an internal control store, which is loaded through a simple write port. It presents the micro-command bits with each bit qualified by the phase it belongs to.

A microword is 25 bits wide. From most to least significant it holds 17 command bits, a dispatch test bit, a sign test bit and a 6-bit next-address field. The sequencer needs no adder and no address multiplexer to branch. Instead, during T4 it sets chosen bits of the micro-address register to one. With the dispatch test bit set, the four opcode bits are ORed into address bits 3..0, which gives a 16-way dispatch. With the sign test bit set and the sign flag clear, address bit 4 is set, which gives a 2-way branch.

Top module: `useq_core`

## Requirements
- R1: While `rst_n` is low, and at once when it falls, `ph_t2`, `ph_t3`, `ph_t4`, `uaddr` and `cmd` are all zero. After release, execution starts from micro-address 0.
- R2: After reset, the phase outputs repeat a four-clock pattern: no strobe, then `ph_t2`, then `ph_t3`, then `ph_t4`. At most one strobe is high in any clock.
- R3: At the clock edge that ends the `ph_t2` clock, two things happen. `uaddr` takes the next-address field (bits 5..0) of the control-store word at the address `uaddr` held during that clock. The command bits (24..8) of that same word become the active command set.
- R4: At the edge that ends the `ph_t4` clock, if the active word has bit 7 set, `uaddr[3:0]` becomes its old value ORed with `opcode[3:0]`.
- R5: At that same edge, if the active word has bit 6 set and `sign_flag` is 0, `uaddr[4]` is set. If `sign_flag` is 1, bit 4 keeps its value.
- R6: Forcing never clears a micro-address bit. If neither test bit is set, `uaddr` is unchanged across the `ph_t4` edge.
- R7: Command outputs 7..0 (word bits 15..8) can be high only while `ph_t4` is high. During `ph_t4` each one equals its word bit.
- R8: Command outputs 11..8 (word bits 19..16) can be high only while `ph_t3` is high. During `ph_t3` each one equals its word bit.
- R9: Command outputs 16..12 (word bits 24..20) follow the active word in every clock, whatever the phase.
- R10: `opcode` and `sign_flag` affect only the edge at the end of `ph_t4`. Values present in other clocks leave `uaddr` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cs_we | input | 1 | Control-store write enable |
| cs_waddr | input | 6 | Control-store write address |
| cs_wdata | input | 25 | Control-store write word |
| opcode | input | 4 | Instruction opcode bits used for dispatch |
| sign_flag | input | 1 | Latched sign flag used for the 2-way branch |
| ph_t2 | output | 1 | Phase strobe T2 |
| ph_t3 | output | 1 | Phase strobe T3 |
| ph_t4 | output | 1 | Phase strobe T4 |
| uaddr | output | 6 | Current micro-address |
| cmd | output | 17 | Phase-qualified micro-command bits |

## Verification
The hardest case to reach is the forcing step. Its result depends on a test bit inside the active microword and on the `opcode` and `sign_flag` values at one particular edge, and the only way to observe it is `uaddr` in the following clock. The stimulus writes a crafted word at address 0 and fills every other address with a computed word. It then releases reset, so the crafted word is the first one active. During the idle clock and T2 the bench drives the inverted opcode and sign values. It applies the real values only in the T4 clock. This shows both the forced result and that values outside T4 are ignored. One more machine cycle then fetches from the forced address, which shows that the store read follows the forced address.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int UA_W    = 6;
  localparam int CMD_W   = 17;
  localparam int OP_W    = 4;
  localparam int PH_W    = 2;
  localparam int TEST_W  = 2;
  localparam int WORD_W  = CMD_W + TEST_W + UA_W;
  localparam int DEPTH   = 1 << UA_W;
  localparam int SGN_BIT = OP_W;

  typedef struct packed {
    logic [CMD_W-1:0] cmd;
    logic             t_disp;
    logic             t_sign;
    logic [UA_W-1:0]  nxt;
  } uword_t;
endpackage

// File: rtl/useq_phase.sv
module useq_phase
  import useq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  output logic t2,
  output logic t3,
  output logic t4
);
  logic [PH_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign t2 = (cnt_q == PH_W'(1));
  assign t3 = (cnt_q == PH_W'(2));
  assign t4 = (cnt_q == PH_W'(3));

  // R2
  one_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({t2, t3, t4}));
  // R2
  t2_to_t3_chk: assert property (@(posedge clk) disable iff (!rst_n)
    t2 |=> t3);
  // R2
  t3_to_t4_chk: assert property (@(posedge clk) disable iff (!rst_n)
    t3 |=> t4);
  // R2
  t4_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    t4 |=> !(t2 || t3 || t4));
endmodule

// File: rtl/useq_store.sv
module useq_store
  import useq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [UA_W-1:0] waddr,
  input  uword_t          wdata,
  input  logic [UA_W-1:0] raddr,
  output uword_t          rdata
);
  uword_t mem [DEPTH];
  uword_t rd_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= mem[raddr];
  end

  assign rdata = rd_q;
endmodule

// File: rtl/useq_addr.sv
module useq_addr
  import useq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             t2,
  input  logic             t4,
  input  uword_t           fetched,
  input  logic [OP_W-1:0]  opcode,
  input  logic             sign_flag,
  output logic [UA_W-1:0]  uar,
  output logic [CMD_W-1:0] cmd_raw
);
  uword_t          mir_q, mir_d;
  logic [UA_W-1:0] uar_q, uar_d;
  logic [UA_W-1:0] force_v;

  always_comb begin
    force_v = '0;
    if (mir_q.t_disp) force_v[OP_W-1:0] = opcode;
    if (mir_q.t_sign && !sign_flag) force_v[SGN_BIT] = 1'b1;
  end

  always_comb begin
    uar_d = uar_q;
    mir_d = mir_q;
    if (t2) begin
      uar_d = fetched.nxt;
      mir_d = fetched;
    end else if (t4) begin
      uar_d = uar_q | force_v;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uar_q <= '0;
      mir_q <= '0;
    end else begin
      uar_q <= uar_d;
      mir_q <= mir_d;
    end
  end

  assign uar     = uar_q;
  assign cmd_raw = mir_q.cmd;

  // R6
  no_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    t4 |=> ((uar_q & $past(uar_q)) == $past(uar_q)));
  // R10
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!t2 && !t4) |=> $stable(uar_q));
  // R5
  sign_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (t4 && mir_q.t_sign && !sign_flag) |=> uar_q[SGN_BIT]);
  // R4
  dispatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (t4 && mir_q.t_disp) |=> ((uar_q[OP_W-1:0] & $past(opcode)) == $past(opcode)));
endmodule

// File: rtl/useq_gate.sv
module useq_gate
  import useq_pkg::*;
#(
  parameter logic [CMD_W-1:0] T4_MASK = 17'h000FF,
  parameter logic [CMD_W-1:0] T3_MASK = 17'h00F00
)(
  input  logic             t3,
  input  logic             t4,
  input  logic [CMD_W-1:0] raw,
  output logic [CMD_W-1:0] gated
);
  for (genvar gi = 0; gi < CMD_W; gi++) begin : g_bit
    if (T4_MASK[gi]) begin : g_t4
      assign gated[gi] = raw[gi] & t4;
    end else if (T3_MASK[gi]) begin : g_t3
      assign gated[gi] = raw[gi] & t3;
    end else begin : g_pass
      assign gated[gi] = raw[gi];
    end
  end
endmodule

// File: rtl/useq_core.sv
module useq_core
  import useq_pkg::*;
#(
  parameter logic [CMD_W-1:0] T4_MASK = 17'h000FF,
  parameter logic [CMD_W-1:0] T3_MASK = 17'h00F00
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_we,
  input  logic [UA_W-1:0]   cs_waddr,
  input  logic [WORD_W-1:0] cs_wdata,
  input  logic [OP_W-1:0]   opcode,
  input  logic              sign_flag,
  output logic              ph_t2,
  output logic              ph_t3,
  output logic              ph_t4,
  output logic [UA_W-1:0]   uaddr,
  output logic [CMD_W-1:0]  cmd
);
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  uword_t           fetched;
  uword_t           wword;
  logic [CMD_W-1:0] cmd_raw;
  logic [UA_W-1:0]  uar;

  assign wword = uword_t'(cs_wdata);

  useq_phase u_phase (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .t2    (ph_t2),
    .t3    (ph_t3),
    .t4    (ph_t4)
  );

  useq_store u_store (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .we    (cs_we),
    .waddr (cs_waddr),
    .wdata (wword),
    .raddr (uar),
    .rdata (fetched)
  );

  useq_addr u_addr (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .t2        (ph_t2),
    .t4        (ph_t4),
    .fetched   (fetched),
    .opcode    (opcode),
    .sign_flag (sign_flag),
    .uar       (uar),
    .cmd_raw   (cmd_raw)
  );

  useq_gate #(.T4_MASK(T4_MASK), .T3_MASK(T3_MASK)) u_gate (
    .t3    (ph_t3),
    .t4    (ph_t4),
    .raw   (cmd_raw),
    .gated (cmd)
  );

  assign uaddr = uar;

  // R7
  t4_gate_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (|(cmd & T4_MASK)) |-> ph_t4);
  // R8
  t3_gate_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (|(cmd & T3_MASK)) |-> ph_t3);
endmodule

// File: tb/sim_useq_core.sv
module sim_useq_core;
  localparam int CLK_PERIOD = 10;
  localparam logic [16:0] M_T4   = 17'h000FF;
  localparam logic [16:0] M_T3   = 17'h00F00;
  localparam logic [16:0] M_PASS = 17'h1F000;
  localparam int NV = 10;
  // fields: next(6) disp(1) sign_test(1) opcode(4) sign(1) cmd(17) expected(6)
  localparam logic [35:0] VEC [NV] = '{
    {6'h20, 1'b1, 1'b0, 4'hA, 1'b0, 17'h1FFFF, 6'h2A},
    {6'h05, 1'b1, 1'b0, 4'h3, 1'b1, 17'h0A5A5, 6'h07},
    {6'h0F, 1'b1, 1'b0, 4'h0, 1'b0, 17'h15A5A, 6'h0F},
    {6'h21, 1'b0, 1'b1, 4'h6, 1'b0, 17'h00F0F, 6'h31},
    {6'h21, 1'b0, 1'b1, 4'h6, 1'b1, 17'h1F0F0, 6'h21},
    {6'h12, 1'b0, 1'b1, 4'h0, 1'b0, 17'h12345, 6'h12},
    {6'h08, 1'b1, 1'b1, 4'h5, 1'b0, 17'h0FF00, 6'h1D},
    {6'h30, 1'b0, 1'b0, 4'hF, 1'b0, 17'h000FF, 6'h30},
    {6'h3F, 1'b1, 1'b1, 4'h0, 1'b0, 17'h1E001, 6'h3F},
    {6'h01, 1'b1, 1'b0, 4'hF, 1'b1, 17'h00000, 6'h0F}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs_we;
  logic [5:0]  cs_waddr;
  logic [24:0] cs_wdata;
  logic [3:0]  opcode;
  logic        sign_flag;
  logic        ph_t2, ph_t3, ph_t4;
  logic [5:0]  uaddr;
  logic [16:0] cmd;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  useq_core u0 (
    .clk(clk), .rst_n(rst_n), .cs_we(cs_we), .cs_waddr(cs_waddr),
    .cs_wdata(cs_wdata), .opcode(opcode), .sign_flag(sign_flag),
    .ph_t2(ph_t2), .ph_t3(ph_t3), .ph_t4(ph_t4), .uaddr(uaddr), .cmd(cmd)
  );

  function automatic logic [24:0] dflt_word(input logic [5:0] a);
    return {a, a, a[4:0], 2'b00, a ^ 6'h15};
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [24:0] d);
    cs_we = 1'b1; cs_waddr = a; cs_wdata = d;
    tick();
    cs_we = 1'b0;
  endtask

  task automatic wait_t2();
    for (int k = 0; k < 12; k++) begin
      if (ph_t2) break;
      tick();
    end
  endtask

  initial begin
    rst_n = 1'b0; cs_we = 1'b0; cs_waddr = '0; cs_wdata = '0;
    opcode = '0; sign_flag = 1'b0;
    #1;
    // R1: reset state
    chk("R1 phases", {29'd0, ph_t2, ph_t3, ph_t4}, 32'd0);
    chk("R1 uaddr", {26'd0, uaddr}, 32'd0);
    chk("R1 cmd", {15'd0, cmd}, 32'd0);
    for (int a = 0; a < 64; a++) wr(6'(a), dflt_word(6'(a)));

    // R2: phase sequence
    rst_n = 1'b1;
    wait_t2();
    chk("R2 t2 seen", {31'd0, ph_t2}, 32'd1);
    for (int k = 1; k <= 8; k++) begin
      tick();
      chk("R2 phase pattern", {29'd0, ph_t2, ph_t3, ph_t4},
          (k % 4 == 1) ? 32'd2 : (k % 4 == 2) ? 32'd1 : (k % 4 == 3) ? 32'd0 : 32'd4);
    end

    // R1: reset asserted mid-run clears at once
    rst_n = 1'b0;
    #1;
    chk("R1 async phases", {29'd0, ph_t2, ph_t3, ph_t4}, 32'd0);
    chk("R1 async uaddr", {26'd0, uaddr}, 32'd0);
    chk("R1 async cmd", {15'd0, cmd}, 32'd0);

    for (int v = 0; v < NV; v++) begin
      logic [5:0]  nx, ex;
      logic        dp, st, sg;
      logic [3:0]  op;
      logic [16:0] cw;
      logic [24:0] fw;
      {nx, dp, st, op, sg, cw, ex} = VEC[v];
      rst_n = 1'b0;
      tick();
      wr(6'd0, {cw, dp, st, nx});
      opcode = ~op; sign_flag = ~sg;
      rst_n = 1'b1;
      wait_t2();
      tick(); // T3 clock
      chk("R3 next field", {26'd0, uaddr}, {26'd0, nx});
      chk("R8 T3 cmd", {15'd0, cmd}, {15'd0, cw & (M_T3 | M_PASS)});
      tick(); // T4 clock
      chk("R10 uaddr held", {26'd0, uaddr}, {26'd0, nx});
      chk("R7 T4 cmd", {15'd0, cmd}, {15'd0, cw & (M_T4 | M_PASS)});
      opcode = op; sign_flag = sg;
      tick(); // idle clock
      chk("R4 R5 R6 forced uaddr", {26'd0, uaddr}, {26'd0, ex});
      chk("R9 pass cmd", {15'd0, cmd}, {15'd0, cw & M_PASS});
      opcode = ~op; sign_flag = ~sg;
      tick(); // T2
      tick(); // T3 of next cycle
      fw = dflt_word(ex);
      chk("R3 fetch from forced", {26'd0, uaddr}, {26'd0, fw[5:0]});
      chk("R3 cmd from forced", {15'd0, cmd}, {15'd0, fw[24:8] & (M_T3 | M_PASS)});
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end
endmodule